// File: doc/BRIEF.md
# Button-Sequenced Two-Operand Adder/Subtractor

This block takes two 8-bit unsigned operands from a single shared switch bus and combines them under the control of one "enter" push button. A small phase controller decides what the output shows. Out of reset the output follows the switches directly. The first press stores operand A, and the output then shows A. The second press stores operand B, and the output becomes A+B. Each press after that swaps the output between the difference and the sum, with no limit on the number of presses.

The arithmetic core is combinational and takes a 2-bit function code. It produces an 8-bit result together with a negative flag and an overflow flag. A sum above 255 raises the overflow flag and keeps the low 8 bits. A difference with A<B raises the negative flag and reports the magnitude B-A. The button is assumed to be debounced already. The block detects its rising edge, so a held button counts as one press. All outputs are registered.

Top module: `btn_alu`

## Requirements
- R1: While the synchronous reset is high, the output register holds result 0 with both flags 0. Reset clears both operand registers and returns the controller to the live phase.
- R2: In the live phase, the result equals the switch value sampled at the previous clock edge, and both flags are 0.
- R3: The first press stores the switch value as operand A. The output then shows A (function 00) and does not follow further switch changes.
- R4: The second press stores the switch value as operand B, and the output becomes A+B.
- R5: When A+B exceeds 255, the overflow flag is 1 and the result is A+B-256. Otherwise the overflow flag is 0.
- R6: Every press after the second alternates the output: sum, then difference, then sum again, and so on without limit.
- R7: For the difference, A>=B gives result A-B with the negative flag 0, and A<B gives result B-A with the negative flag 1. The negative and overflow flags are never 1 at the same time.
- R8: A press is recognised on the rising edge of the enter input. Holding the button for many cycles advances the sequence by exactly one step.
- R9: At most one operand register loads in any cycle, and it loads only on the first or second press. Switch changes in the sum and difference phases leave both operands unchanged.
- R10: The function codes are 00 pass A, 01 pass B, 10 A+B and 11 A-B. In both pass modes the negative and overflow flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enter_btn | input | 1 | Debounced enter button, active high |
| sw_in | input | 8 | Shared switch bus supplying both operands |
| res_out | output | 8 | Registered result |
| neg_flag | output | 1 | Registered negative-difference flag |
| ovf_flag | output | 1 | Registered sum-overflow flag |

## Verification
In the live phase a switch change reaches `res_out` one clock edge later, because only the output register lies in the path. A press first takes effect at the edge that samples `enter_btn` high, which updates the phase and the operand registers. Its result appears one edge after that, so the output changes two edges after the button is first sampled high. The bench drives inputs on falling edges and holds each press for several cycles. It then waits at least two further edges before sampling on a falling edge, so every comparison sees a settled output. The held-button scenario keeps enter high for many cycles and checks that the sequence advanced by exactly one step.

// File: rtl/btn_alu_pkg.sv
package btn_alu_pkg;
  typedef enum logic [1:0] {
    FN_PASS_A = 2'b00,
    FN_PASS_B = 2'b01,
    FN_ADD    = 2'b10,
    FN_SUB    = 2'b11
  } alu_fn_e;

  typedef enum logic [1:0] {
    PH_LIVE  = 2'b00,
    PH_GOT_A = 2'b01,
    PH_SUM   = 2'b10,
    PH_DIFF  = 2'b11
  } phase_e;
endpackage

// File: rtl/press_detect.sv
module press_detect (
  input  logic clk,
  input  logic rst,
  input  logic btn,
  output logic press
);
  logic btn_q;

  always_ff @(posedge clk) begin
    if (rst) btn_q <= 1'b0;
    else     btn_q <= btn;
  end

  assign press = btn & ~btn_q;

  // R8: a press never lasts two consecutive cycles
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import btn_alu_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    press,
  output logic    ld_a,
  output logic    ld_b,
  output logic    live_sel,
  output alu_fn_e fn
);
  phase_e phase, phase_nx;

  always_comb begin
    phase_nx = phase;
    if (press) begin
      case (phase)
        PH_LIVE:  phase_nx = PH_GOT_A;
        PH_GOT_A: phase_nx = PH_SUM;
        PH_SUM:   phase_nx = PH_DIFF;
        default:  phase_nx = PH_SUM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_LIVE;
    else     phase <= phase_nx;
  end

  assign ld_a     = press && (phase == PH_LIVE);
  assign ld_b     = press && (phase == PH_GOT_A);
  assign live_sel = (phase == PH_LIVE);

  always_comb begin
    case (phase)
      PH_SUM:  fn = FN_ADD;
      PH_DIFF: fn = FN_SUB;
      default: fn = FN_PASS_A;
    endcase
  end

  // R9: never both operand loads in one cycle
  a_r9_one_load: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_a, ld_b}));
  // R6: sum and difference alternate on each press
  a_r6_sum_to_diff: assert property (@(posedge clk) disable iff (rst)
    (press && phase == PH_SUM) |=> (phase == PH_DIFF));
  a_r6_diff_to_sum: assert property (@(posedge clk) disable iff (rst)
    (press && phase == PH_DIFF) |=> (phase == PH_SUM));
  // R8: without a press the phase holds
  a_r8_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !press |=> $stable(phase));
endmodule

// File: rtl/opnd_regs.sv
module opnd_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_a,
  input  logic         ld_b,
  input  logic [W-1:0] din,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (ld_a) a_q <= din;
      if (ld_b) b_q <= din;
    end
  end

  // R9: operands change only on their own load strobe
  a_r9_a_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_a |=> $stable(a_q));
  a_r9_b_hold: assert property (@(posedge clk) disable iff (rst)
    !ld_b |=> $stable(b_q));
endmodule

// File: rtl/alu_core.sv
module alu_core
  import btn_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] res,
  output logic         neg,
  output logic         ovf
);
  logic [W:0] sum_w;
  assign sum_w = {1'b0, a} + {1'b0, b};

  always_comb begin
    res = a;
    neg = 1'b0;
    ovf = 1'b0;
    case (fn)
      FN_PASS_A: res = a;
      FN_PASS_B: res = b;
      FN_ADD: begin
        res = sum_w[W-1:0];
        ovf = sum_w[W];
      end
      default: begin
        if (a >= b) begin
          res = a - b;
        end else begin
          res = b - a;
          neg = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/btn_alu.sv
module btn_alu
  import btn_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enter_btn,
  input  logic [W-1:0] sw_in,
  output logic [W-1:0] res_out,
  output logic         neg_flag,
  output logic         ovf_flag
);
  logic         press, ld_a, ld_b, live_sel;
  alu_fn_e      fn;
  logic [W-1:0] a_q, b_q, alu_res;
  logic         alu_neg, alu_ovf;

  press_detect u_press (
    .clk(clk), .rst(rst), .btn(enter_btn), .press(press)
  );

  seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .press(press),
    .ld_a(ld_a), .ld_b(ld_b), .live_sel(live_sel), .fn(fn)
  );

  opnd_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .ld_a(ld_a), .ld_b(ld_b),
    .din(sw_in), .a_q(a_q), .b_q(b_q)
  );

  alu_core #(.W(W)) u_alu (
    .a(a_q), .b(b_q), .fn(fn),
    .res(alu_res), .neg(alu_neg), .ovf(alu_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out  <= '0;
      neg_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else if (live_sel) begin
      res_out  <= sw_in;
      neg_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      res_out  <= alu_res;
      neg_flag <= alu_neg;
      ovf_flag <= alu_ovf;
    end
  end

  // R7: the two flags are mutually exclusive
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(neg_flag && ovf_flag));
  // R10: pass modes leave both flags clear
  a_r10_pass_clear: assert property (@(posedge clk) disable iff (rst)
    (fn == FN_PASS_A || fn == FN_PASS_B) |=> (!neg_flag && !ovf_flag));
  // R2: live phase follows the switches one edge later
  a_r2_live_follow: assert property (@(posedge clk) disable iff (rst)
    live_sel |=> (res_out == $past(sw_in)));
  // R5: an addition never reports a negative result
  a_r5_add_not_neg: assert property (@(posedge clk) disable iff (rst)
    (fn == FN_ADD) |=> !neg_flag);
endmodule

// File: tb/btn_alu_test.sv
module btn_alu_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enter_btn = 1'b0;
  logic [7:0] sw_in = 8'h00;
  logic [7:0] res_out;
  logic       neg_flag, ovf_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  btn_alu uut (
    .clk(clk), .rst(rst), .enter_btn(enter_btn), .sw_in(sw_in),
    .res_out(res_out), .neg_flag(neg_flag), .ovf_flag(ovf_flag)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] er,
                     input logic en, input logic eo);
    n_chk++;
    if (res_out !== er || neg_flag !== en || ovf_flag !== eo) begin
      n_fail++;
      $display("FAIL %s: got res=%0d neg=%0b ovf=%0b, expected res=%0d neg=%0b ovf=%0b",
               tag, res_out, neg_flag, ovf_flag, er, en, eo);
    end
  endtask

  task automatic press(input int hold);
    enter_btn = 1'b1;
    step(hold);
    enter_btn = 1'b0;
    step(3);
  endtask

  task automatic do_reset();
    enter_btn = 1'b0;
    rst = 1'b1;
    step(2);
    chk("R1 reset outputs", 8'd0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  function automatic logic [9:0] exp_sum(input int a, input int b);
    int s = a + b;
    return {1'b0, (s > 255), 8'(s)};
  endfunction

  function automatic logic [9:0] exp_diff(input int a, input int b);
    if (a >= b) return {2'b00, 8'(a - b)};
    return {2'b10, 8'(b - a)};
  endfunction

  task automatic chk_pack(input string tag, input logic [9:0] e);
    chk(tag, e[7:0], e[9], e[8]);
  endtask

  task automatic t_live();
    do_reset();
    sw_in = 8'h5A; step(1);
    chk("R2 live 0x5A", 8'h5A, 1'b0, 1'b0);
    sw_in = 8'hC3; step(1);
    chk("R2 live 0xC3", 8'hC3, 1'b0, 1'b0);
  endtask

  task automatic t_sequence();
    do_reset();
    sw_in = 8'd100; press(2);
    chk("R3 R10 shows A", 8'd100, 1'b0, 1'b0);
    sw_in = 8'd7; step(2);
    chk("R3 A ignores switches", 8'd100, 1'b0, 1'b0);
    sw_in = 8'd50; press(2);
    chk_pack("R4 first sum", exp_sum(100, 50));
    sw_in = 8'd255; step(2);
    chk_pack("R9 operands held", exp_sum(100, 50));
    press(2);
    chk_pack("R6 R7 difference", exp_diff(100, 50));
    press(12);
    chk_pack("R8 long hold one step", exp_sum(100, 50));
    press(1);
    chk_pack("R6 back to diff", exp_diff(100, 50));
  endtask

  task automatic t_pair(input int a, input int b, input string tag);
    do_reset();
    sw_in = 8'(a); press(2);
    sw_in = 8'(b); press(2);
    chk_pack({tag, " sum"}, exp_sum(a, b));
    sw_in = ~sw_in; press(2);
    chk_pack({tag, " diff"}, exp_diff(a, b));
  endtask

  task automatic t_toggle_many();
    do_reset();
    sw_in = 8'd9;  press(2);
    sw_in = 8'd30; press(2);
    for (int i = 0; i < 8; i++) begin
      sw_in = 8'(i * 37);
      press(2);
      if (i % 2 == 0) chk_pack("R6 toggle diff", exp_diff(9, 30));
      else            chk_pack("R6 toggle sum", exp_sum(9, 30));
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(1);
    t_live();
    t_sequence();
    t_pair(20, 200, "R7 negative");
    t_pair(200, 100, "R5 overflow");
    t_pair(128, 128, "R5 equal operands");
    t_pair(255, 0, "R5 no overflow edge");
    t_toggle_many();
    do_reset();
    sw_in = 8'd77; step(1);
    chk("R1 reset back to live", 8'd77, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule